// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls a port of sixteen general-purpose pins through a small word-addressed register interface. Each pin carries a four-bit setting: a two-bit mode field (`[1:0]` of the nibble) and a two-bit function field (`[3:2]`). From that setting, the output data register and a sixteen-bit alternate-function bus, the block drives the pad controls for every pin. These controls are the output value, the output enable, an open-drain qualifier, pull-up and pull-down requests, an alternate-function select and the unchanged speed code.

Pad levels enter through a two-stage synchroniser before software can read them. A set/clear register changes single output bits without a read-modify-write. A five-access lock sequence freezes the settings of chosen pins until the next reset.

Register word addresses are: 0 pin settings 0–7, 1 pin settings 8–15 (pin p uses nibble bits `[4*(p%8)+3 : 4*(p%8)]`), 2 input data (read only), 3 output data, 4 set/clear (write only), 5 lock (bit 16 is the key, bits 15:0 the pin mask).

Top module: `gpio_port`

## Requirements
- R1: After reset every pin nibble reads 4'b0100 (floating input), so both setting words read 32'h4444_4444. Output data reads 0, and no pin has its output enable or a pull request asserted.
- R2: A pin with mode 00 and function 10 requests pull-up when its output data bit is 1 and pull-down when it is 0. Every other setting requests neither pull.
- R3: Mode bits of pin p appear unchanged on `speed_o[2p+1:2p]`. Mode 00 keeps the pin an input, with output enable, output value, open-drain and alternate select all 0.
- R4: In output mode, function 00 drives the output data bit with the output enable set.
- R5: In output mode, function bit 2 set (01 or 11) asserts `pad_od_o` and raises the output enable only while the driven value is 0.
- R6: In output mode, function bit 3 set (10 or 11) drives the pin from `af_data_i` and asserts `af_sel_o`.
- R7: A write to address 4 clears the output bits given in wdata[31:16] and sets those given in wdata[15:0]. Where both name a bit, the bit ends up 1.
- R8: Address 2 reads the pad levels through two flops, so a pad change is visible after the second rising edge and not after the first. A pin with mode 00 and function 00 (analog) reads 0.
- R9: The lock becomes active only after exactly this series of accesses to address 5: a write with key 1 and mask M, a write with key 0 and mask M, a write with key 1 and mask M, then two reads. Reading address 5 returns the active flag in bit 16 and the frozen mask in bits 15:0.
- R10: Setting writes leave the nibbles of locked pins unchanged while unlocked pins in the same word update. The lock persists until reset.
- R11: Any other access to address 5 during the sequence, such as a wrong key, a different mask or an early read, abandons it with no pin locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req_i | input | 1 | Access request, one cycle per access |
| bus_we_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 3 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the request cycle |
| pad_in_i | input | 16 | Pad levels, asynchronous |
| af_data_i | input | 16 | Alternate-function output data per pin |
| pad_out_o | output | 16 | Output value per pin |
| pad_oe_o | output | 16 | Output enable per pin |
| pad_od_o | output | 16 | Open-drain qualifier per pin |
| pull_up_o | output | 16 | Pull-up request per pin |
| pull_dn_o | output | 16 | Pull-down request per pin |
| af_sel_o | output | 16 | Alternate-function select per pin |
| speed_o | output | 32 | Mode/speed code, two bits per pin |

## Verification
On every cycle the assertions check the following pad-side invariants:
- An open-drain pin is never enabled while driving 1.
- Pull-up and pull-down are never requested together.
- An enabled pin has a non-zero speed code.
- Locked nibbles never change.
- The lock mask only grows and needs an active lock.
- Bits named in a set/clear write end up set.

Only the bench scenarios can show the rest: the full decode of each mode and function pair, the two-edge input latency, analog reads of zero, the set-wins priority, and that broken lock sequences leave the pins writable.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int NPIN         = 16;
    localparam int BUS_W        = 32;
    localparam int ADDR_W       = 3;
    localparam int NIB_W        = 4;
    localparam int PINS_PER_CFG = BUS_W / NIB_W;
    localparam int SYNC_STAGES  = 2;
    localparam int LOCK_KEY_BIT = NPIN;

    localparam logic [ADDR_W-1:0] A_CFG_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_CFG_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_IDR    = 3'd2;
    localparam logic [ADDR_W-1:0] A_ODR    = 3'd3;
    localparam logic [ADDR_W-1:0] A_SETCLR = 3'd4;
    localparam logic [ADDR_W-1:0] A_LOCK   = 3'd5;

    typedef enum logic [1:0] {
        MD_IN   = 2'b00,
        MD_10M  = 2'b01,
        MD_2M   = 2'b10,
        MD_50M  = 2'b11
    } mode_e;

    typedef struct packed {
        logic [1:0] fn;
        mode_e      mode;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{fn: 2'b01, mode: MD_IN};

    typedef struct packed {
        logic out;
        logic oe;
        logic od;
        logic pu;
        logic pd;
        logic afsel;
    } pin_drive_t;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ARM1,
        LK_ARM0,
        LK_ARM1B,
        LK_READ1,
        LK_DONE
    } lock_state_e;

    function automatic logic is_analog(pin_cfg_t c);
        return (c.mode == MD_IN) && (c.fn == 2'b00);
    endfunction

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_lock.sv
module gpio_port_lock
    import gpio_port_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            acc_i,
    input  logic            we_i,
    input  logic            key_i,
    input  logic [NPIN-1:0] mask_i,
    output logic [NPIN-1:0] lock_mask_o,
    output logic            active_o
);
    lock_state_e     state_q;
    logic [NPIN-1:0] cand_q;
    logic [NPIN-1:0] mask_q;
    logic            same;

    assign same = (mask_i == cand_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LK_IDLE;
            cand_q  <= '0;
            mask_q  <= '0;
        end else if (acc_i) begin
            unique case (state_q)
                LK_IDLE: if (we_i && key_i) begin
                    state_q <= LK_ARM1;
                    cand_q  <= mask_i;
                end
                LK_ARM1:  state_q <= (we_i && !key_i && same) ? LK_ARM0  : LK_IDLE;
                LK_ARM0:  state_q <= (we_i && key_i && same)  ? LK_ARM1B : LK_IDLE;
                LK_ARM1B: state_q <= (!we_i) ? LK_READ1 : LK_IDLE;
                LK_READ1: if (!we_i) begin
                    state_q <= LK_DONE;
                    mask_q  <= mask_q | cand_q;
                end else begin
                    state_q <= LK_IDLE;
                end
                LK_DONE:  state_q <= LK_DONE;
                default:  state_q <= LK_IDLE;
            endcase
        end
    end

    assign active_o    = (state_q == LK_DONE);
    assign lock_mask_o = mask_q;

    assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        active_o |=> active_o);
    assert_mask_grows_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((lock_mask_o & $past(lock_mask_o)) == $past(lock_mask_o)));
    assert_mask_needs_active_R9: assert property (@(posedge clk) disable iff (rst)
        (|lock_mask_o) |-> active_o);
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_i,
    input  logic                  we_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [BUS_W-1:0]      wdata_i,
    input  logic [NPIN-1:0]       lock_mask_i,
    input  logic                  lock_active_i,
    input  logic [NPIN-1:0]       idr_i,
    output logic [BUS_W-1:0]      rdata_o,
    output pin_cfg_t [NPIN-1:0]   cfg_o,
    output logic [NPIN-1:0]       odr_o
);
    localparam int NCFG = NPIN / PINS_PER_CFG;

    pin_cfg_t [NPIN-1:0] cfg_q;
    logic [NPIN-1:0]     odr_q;
    logic                wr;
    logic                rd;

    assign wr = req_i && we_i;
    assign rd = req_i && !we_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < NPIN; p++) cfg_q[p] <= CFG_RESET;
        end else if (wr) begin
            for (int p = 0; p < NPIN; p++) begin
                if (addr_i == A_CFG_LO + ADDR_W'(p / PINS_PER_CFG) && !lock_mask_i[p])
                    cfg_q[p] <= pin_cfg_t'(wdata_i[(p % PINS_PER_CFG)*NIB_W +: NIB_W]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            odr_q <= '0;
        end else if (wr && addr_i == A_ODR) begin
            odr_q <= wdata_i[NPIN-1:0];
        end else if (wr && addr_i == A_SETCLR) begin
            odr_q <= (odr_q & ~wdata_i[2*NPIN-1:NPIN]) | wdata_i[NPIN-1:0];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (rd) begin
            for (int w = 0; w < NCFG; w++) begin
                if (addr_i == A_CFG_LO + ADDR_W'(w)) begin
                    for (int i = 0; i < PINS_PER_CFG; i++)
                        rdata_o[i*NIB_W +: NIB_W] = cfg_q[w*PINS_PER_CFG + i];
                end
            end
            if (addr_i == A_IDR)  rdata_o[NPIN-1:0] = idr_i;
            if (addr_i == A_ODR)  rdata_o[NPIN-1:0] = odr_q;
            if (addr_i == A_LOCK) rdata_o[NPIN:0]   = {lock_active_i, lock_mask_i};
        end
    end

    assign cfg_o = cfg_q;
    assign odr_o = odr_q;

    for (genvar p = 0; p < NPIN; p++) begin : g_lock_chk
        assert_locked_cfg_frozen_R10: assert property (@(posedge clk) disable iff (rst)
            lock_mask_i[p] |=> $stable(cfg_q[p]));
    end

    assert_set_bits_land_R7: assert property (@(posedge clk) disable iff (rst)
        (wr && addr_i == A_SETCLR) |=>
            ((odr_q & $past(wdata_i[NPIN-1:0])) == $past(wdata_i[NPIN-1:0])));
endmodule

// File: rtl/gpio_port_pin.sv
module gpio_port_pin
    import gpio_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pin_cfg_t   cfg_i,
    input  logic       odr_i,
    input  logic       af_i,
    output pin_drive_t drv_o
);
    logic is_out;
    logic use_af;
    logic val;
    logic pull_sel;

    always_comb begin
        is_out   = (cfg_i.mode != MD_IN);
        use_af   = is_out && cfg_i.fn[1];
        val      = use_af ? af_i : odr_i;
        pull_sel = !is_out && (cfg_i.fn == 2'b10);

        drv_o.od    = is_out && cfg_i.fn[0];
        drv_o.out   = is_out && val;
        drv_o.oe    = is_out && (!drv_o.od || !val);
        drv_o.afsel = use_af;
        drv_o.pu    = pull_sel && odr_i;
        drv_o.pd    = pull_sel && !odr_i;
    end

    assert_od_never_drives_high_R5: assert property (@(posedge clk) disable iff (rst)
        (drv_o.oe && drv_o.od) |-> !drv_o.out);
    assert_single_pull_R2: assert property (@(posedge clk) disable iff (rst)
        !(drv_o.pu && drv_o.pd));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_req_i,
    input  logic                bus_we_i,
    input  logic [2:0]          bus_addr_i,
    input  logic [31:0]         bus_wdata_i,
    output logic [31:0]         bus_rdata_o,
    input  logic [15:0]         pad_in_i,
    input  logic [15:0]         af_data_i,
    output logic [15:0]         pad_out_o,
    output logic [15:0]         pad_oe_o,
    output logic [15:0]         pad_od_o,
    output logic [15:0]         pull_up_o,
    output logic [15:0]         pull_dn_o,
    output logic [15:0]         af_sel_o,
    output logic [31:0]         speed_o
);
    pin_cfg_t [NPIN-1:0] cfg;
    logic [NPIN-1:0]     odr;
    logic [NPIN-1:0]     sync_in;
    logic [NPIN-1:0]     analog;
    logic [NPIN-1:0]     idr;
    logic [NPIN-1:0]     lock_mask;
    logic                lock_active;
    logic                lock_acc;

    assign lock_acc = bus_req_i && (bus_addr_i == A_LOCK);

    gpio_port_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pad_in_i),
        .q_o (sync_in)
    );

    gpio_port_lock u_lock (
        .clk         (clk),
        .rst         (rst),
        .acc_i       (lock_acc),
        .we_i        (bus_we_i),
        .key_i       (bus_wdata_i[LOCK_KEY_BIT]),
        .mask_i      (bus_wdata_i[NPIN-1:0]),
        .lock_mask_o (lock_mask),
        .active_o    (lock_active)
    );

    gpio_port_regs u_regs (
        .clk           (clk),
        .rst           (rst),
        .req_i         (bus_req_i),
        .we_i          (bus_we_i),
        .addr_i        (bus_addr_i),
        .wdata_i       (bus_wdata_i),
        .lock_mask_i   (lock_mask),
        .lock_active_i (lock_active),
        .idr_i         (idr),
        .rdata_o       (bus_rdata_o),
        .cfg_o         (cfg),
        .odr_o         (odr)
    );

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        pin_drive_t drv;

        gpio_port_pin u_pin (
            .clk   (clk),
            .rst   (rst),
            .cfg_i (cfg[p]),
            .odr_i (odr[p]),
            .af_i  (af_data_i[p]),
            .drv_o (drv)
        );

        assign pad_out_o[p]     = drv.out;
        assign pad_oe_o[p]      = drv.oe;
        assign pad_od_o[p]      = drv.od;
        assign pull_up_o[p]     = drv.pu;
        assign pull_dn_o[p]     = drv.pd;
        assign af_sel_o[p]      = drv.afsel;
        assign speed_o[2*p +: 2] = cfg[p].mode;
        assign analog[p]        = is_analog(cfg[p]);

        assert_enable_needs_speed_R3: assert property (@(posedge clk) disable iff (rst)
            pad_oe_o[p] |-> (speed_o[2*p +: 2] != 2'b00));
    end

    assign idr = sync_in & ~analog;
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    import gpio_port_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req_i = 1'b0;
    logic        bus_we_i = 1'b0;
    logic [2:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic [15:0] pad_in_i = '0;
    logic [15:0] af_data_i = '0;
    logic [15:0] pad_out_o, pad_oe_o, pad_od_o, pull_up_o, pull_dn_o, af_sel_o;
    logic [31:0] speed_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    gpio_port dut (.*);

    // {mode[1:0], fn[1:0], odr, af, out, oe, od, pu, pd, afsel}
    localparam logic [11:0] VEC [12] = '{
        {2'b00, 2'b01, 1'b0, 1'b0, 6'b000000},
        {2'b00, 2'b10, 1'b1, 1'b0, 6'b000100},
        {2'b00, 2'b10, 1'b0, 1'b0, 6'b000010},
        {2'b00, 2'b00, 1'b1, 1'b0, 6'b000000},
        {2'b01, 2'b00, 1'b1, 1'b0, 6'b110000},
        {2'b10, 2'b00, 1'b0, 1'b1, 6'b010000},
        {2'b11, 2'b01, 1'b0, 1'b0, 6'b011000},
        {2'b11, 2'b01, 1'b1, 1'b0, 6'b101000},
        {2'b01, 2'b10, 1'b0, 1'b1, 6'b110001},
        {2'b10, 2'b11, 1'b0, 1'b1, 6'b101001},
        {2'b10, 2'b11, 1'b1, 1'b0, 6'b011001},
        {2'b00, 2'b11, 1'b1, 1'b1, 6'b000000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_req_i = 1'b0; bus_we_i = 1'b0; bus_wdata_i = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
        #1 d = bus_rdata_o;
        @(negedge clk);
        bus_req_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [31:0] d;
        logic [15:0] m;
        do_reset();

        // R1 reset state
        rd(A_CFG_LO, d); check("R1 cfg lo", d, 32'h4444_4444);
        rd(A_CFG_HI, d); check("R1 cfg hi", d, 32'h4444_4444);
        rd(A_ODR, d);    check("R1 odr", d, 32'h0);
        check("R1 oe/pulls", {pad_oe_o, pull_up_o | pull_dn_o}, 32'h0);

        // Pin decode table on pin 0 (R2 R3 R4 R5 R6)
        for (int i = 0; i < 12; i++) begin
            wr(A_ODR, {31'h0, VEC[i][7]});
            af_data_i = {15'h0, VEC[i][6]};
            wr(A_CFG_LO, {28'h444_4444, VEC[i][9:8], VEC[i][11:10]});
            check($sformatf("R2/R4/R5/R6 vector %0d drive", i),
                  {26'h0, pad_out_o[0], pad_oe_o[0], pad_od_o[0], pull_up_o[0], pull_dn_o[0], af_sel_o[0]},
                  {26'h0, VEC[i][5:0]});
            check($sformatf("R3 vector %0d speed", i), {30'h0, speed_o[1:0]}, {30'h0, VEC[i][11:10]});
        end

        // R7 set/clear with set priority
        wr(A_ODR, 32'h0000_00F0);
        wr(A_SETCLR, {16'h0011, 16'h0101});
        rd(A_ODR, d); check("R7 set/clear", d, 32'h0000_01E1);

        // R8 two-flop input, analog reads 0
        wr(A_CFG_LO, 32'h4444_4440);
        @(negedge clk); pad_in_i = 16'hFFFF;
        @(negedge clk);
        #1 bus_req_i = 1'b1; bus_addr_i = A_IDR;
        #1 check("R8 one edge", bus_rdata_o, 32'h0);
        bus_req_i = 1'b0;
        @(negedge clk);
        #1 bus_req_i = 1'b1; bus_addr_i = A_IDR;
        #1 check("R8 two edges analog masked", bus_rdata_o, 32'h0000_FFFE);
        bus_req_i = 1'b0;

        // R11 abort: wrong key in third step
        m = 16'h0003;
        wr(A_LOCK, {15'h0, 1'b1, m});
        wr(A_LOCK, {15'h0, 1'b0, m});
        wr(A_LOCK, {15'h0, 1'b0, m});
        rd(A_LOCK, d); rd(A_LOCK, d);
        rd(A_LOCK, d); check("R11 wrong key no lock", d, 32'h0);
        wr(A_CFG_LO, 32'h1111_1111);
        rd(A_CFG_LO, d); check("R11 pins still writable", d, 32'h1111_1111);

        // R11 abort: mask changed in second step
        wr(A_LOCK, {15'h0, 1'b1, m});
        wr(A_LOCK, {15'h0, 1'b0, 16'h0001});
        wr(A_LOCK, {15'h0, 1'b1, m});
        rd(A_LOCK, d); rd(A_LOCK, d);
        rd(A_LOCK, d); check("R11 mask change no lock", d, 32'h0);

        // R11 abort: early read
        wr(A_LOCK, {15'h0, 1'b1, m});
        wr(A_LOCK, {15'h0, 1'b0, m});
        rd(A_LOCK, d); rd(A_LOCK, d);
        rd(A_LOCK, d); check("R11 early read no lock", d, 32'h0);

        // R9 valid sequence
        wr(A_LOCK, {15'h0, 1'b1, m});
        wr(A_LOCK, {15'h0, 1'b0, m});
        wr(A_LOCK, {15'h0, 1'b1, m});
        rd(A_LOCK, d); rd(A_LOCK, d);
        rd(A_LOCK, d); check("R9 lock active", d, 32'h0001_0003);

        // R10 locked nibbles frozen, others update
        wr(A_CFG_LO, 32'h2222_2222);
        rd(A_CFG_LO, d); check("R10 locked pins kept", d, 32'h2222_2211);
        wr(A_CFG_HI, 32'h3333_3333);
        rd(A_CFG_HI, d); check("R10 unlocked word", d, 32'h3333_3333);
        do_reset();
        rd(A_LOCK, d);   check("R10 lock cleared by reset", d, 32'h0);
        rd(A_CFG_LO, d); check("R10 cfg reset after lock", d, 32'h4444_4444);

        summary();
    end
endmodule